// File: doc/BRIEF.md
# Serial peripheral master with frame-width-scaled FIFOs

This block is a memory-mapped SPI master. Software writes frames into a transmit queue through a simple register port. While the controller is enabled it sends each queued frame on SCLK and MOSI, with the most significant bit first, and drives a single active-low chip select around each frame. The bits it samples on MISO in the same frame go into a receive queue. Frames can be 1 to 32 bits wide.

Both queues sit on fixed storage of MAXD words. The number of usable entries depends on the programmed frame width: narrow frames get the whole storage, medium frames half of it and wide frames a quarter. Until software first writes the frame-size register after reset, only an eighth of the storage is usable. Three sticky raw events are tracked: frame done, receive overflow and transmit drained. Enable bits in the control register, at the same bit positions as the events, gate them onto two interrupt lines.

Top module: `spi_wfifo_master`

## Requirements
- R1: The register window is 64 bytes, with each register on a word offset. The offsets are: control 0x00, frame size 0x04, status 0x08, clock divider 0x0C, TX data 0x10 (write), RX data 0x14 (read), raw events 0x18, masked events 0x1C, event clear 0x20 (write), compact status 0x24. After reset the registers read as follows: control 0x8102, frame size 0x4, status 0x2440, divider 0x7, compact status 0x7, raw and masked events 0. After reset cs_n is 1, and sclk, irq_xfer and irq_err are 0.
- R2: After reset, each queue holds MAXD/8 entries (4 by default) until the frame-size register is first written. Status bit 11 means TX full and bit 10 means TX empty. A TX data write while TX is full is discarded.
- R3: Writing the frame size F sets the depth of each queue. F from 0 to 8 gives MAXD entries, F from 9 to 16 gives MAXD/2, and F of 17 or more gives MAXD/4.
- R4: A write to the frame-size register empties both queues. After it, status bit 10 (TX empty) and bit 6 (RX empty) read 1.
- R5: While control bit 0 is 1 and TX is not empty, the controller pops one frame and shifts N bits out MSB first. N is F, with 0 counted as 1 and values above 32 as 32. MOSI changes on falling SCLK edges and MISO is sampled on rising edges. The received bits are pushed into RX right-aligned, and raw event bit 2 (frame done) is set.
- R6: Each SCLK period lasts 2*(D+1) system clocks, where D is the divider value. cs_n is low only while a frame is shifting, and sclk rises only while cs_n is low.
- R7: The masked events equal the raw events ANDed with control bits 4:2. irq_xfer is masked bit 2 OR masked bit 4, and irq_err is masked bit 3.
- R8: Writing a 1 to a bit of the event-clear register clears the matching raw event bit. Raw bits written with 0 are kept, and the write has no other effect.
- R9: A frame that completes while RX is full is discarded, and raw event bit 3 (overflow) is set. Status bit 7 means RX full.
- R10: While control bit 0 is 0, no frame starts. cs_n stays 1 and queued TX data stays queued.
- R11: Raw event bit 4 is set when a pop leaves the TX queue empty.
- R12: A read of RX data while RX is empty returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX on the RX data offset) |
| reg_addr | input | 6 | Byte offset in the 64-byte window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| irq_xfer | output | 1 | Frame-done or TX-drained interrupt |
| irq_err | output | 1 | RX overflow interrupt |

## Verification
The bench builds the block with its defaults, MAXD=32 and an 8-bit divider. These defaults give four distinct queue depths (4, 8, 16 and 32), and every depth can be filled to its full flag with a few dozen register writes. MISO is looped back to MOSI, so each received word must equal the sent word masked to the frame width. A monitor on SCLK checks the bit order and the divider period at D=2. The wide-frame depth of 8 keeps the overflow case short: nine back-to-back frames with no RX reads.

// File: rtl/spi_wfifo_master.sv
module spi_wfifo_master #(
  parameter int MAXD = 32,
  parameter int CGW  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n,
  output logic        irq_xfer,
  output logic        irq_err
);
  localparam int AW = $clog2(MAXD);
  localparam int CW = AW + 1;
  localparam logic [5:0] A_CTRL = 6'h00, A_FSZ = 6'h04, A_STAT = 6'h08, A_CLK = 6'h0C,
                         A_TXD  = 6'h10, A_RXD = 6'h14, A_RAW  = 6'h18, A_MSK = 6'h1C,
                         A_CLR  = 6'h20, A_ST8 = 6'h24;

  logic [31:0]    ctrl;
  logic [5:0]     fsz;
  logic [CGW-1:0] cgen;
  logic [CW-1:0]  depth;
  logic [2:0]     ev;

  logic [31:0]   tx_mem [MAXD];
  logic [31:0]   rx_mem [MAXD];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  logic           busy;
  logic [CGW-1:0] div;
  logic [5:0]     left;
  logic [31:0]    tsr, rsr;

  wire w_ctrl = reg_wr && reg_addr == A_CTRL;
  wire w_fsz  = reg_wr && reg_addr == A_FSZ;
  wire w_clk  = reg_wr && reg_addr == A_CLK;
  wire w_txd  = reg_wr && reg_addr == A_TXD;
  wire w_clr  = reg_wr && reg_addr == A_CLR;
  wire r_rxd  = reg_rd && reg_addr == A_RXD;

  wire tx_full  = tx_cnt == depth;
  wire tx_empty = tx_cnt == '0;
  wire rx_full  = rx_cnt == depth;
  wire rx_empty = rx_cnt == '0;

  wire [5:0] nb = (fsz == 6'd0) ? 6'd1 : (fsz > 6'd32) ? 6'd32 : fsz;

  wire tx_push   = w_txd && !tx_full;
  wire start     = ctrl[0] && !busy && !tx_empty && !w_fsz;
  wire tx_pop    = start;
  wire half_tick = div == cgen;
  wire fin       = busy && half_tick && sclk && left == 6'd1;
  wire rx_push   = fin && !rx_full && !w_fsz;
  wire ovf       = fin && rx_full;
  wire rx_pop    = r_rxd && !rx_empty;

  function automatic logic [CW-1:0] depth_for(input logic [5:0] f);
    if (f <= 6'd8)       return CW'(MAXD);
    else if (f <= 6'd16) return CW'(MAXD / 2);
    else                 return CW'(MAXD / 4);
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl  <= 32'h0000_8102;
      fsz   <= 6'd4;
      cgen  <= CGW'(7);
      depth <= CW'(MAXD / 8);
    end else begin
      if (w_ctrl) ctrl <= reg_wdata;
      if (w_clk)  cgen <= reg_wdata[CGW-1:0];
      if (w_fsz) begin
        fsz   <= reg_wdata[5:0];
        depth <= depth_for(reg_wdata[5:0]);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (w_fsz) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (w_fsz) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= reg_wdata;
    if (rx_push) rx_mem[rx_wp] <= rsr;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; sclk <= 1'b0; cs_n <= 1'b1;
      div  <= '0;   left <= '0;   tsr  <= '0; rsr <= '0;
    end else if (start) begin
      busy <= 1'b1; sclk <= 1'b0; cs_n <= 1'b0;
      div  <= '0;   left <= nb;
      tsr  <= tx_mem[tx_rp] << (6'd32 - nb);
      rsr  <= '0;
    end else if (busy) begin
      if (half_tick) begin
        div  <= '0;
        sclk <= ~sclk;
        if (!sclk) rsr <= {rsr[30:0], miso};
        else begin
          tsr  <= tsr << 1;
          left <= left - 6'd1;
          if (left == 6'd1) begin
            busy <= 1'b0;
            cs_n <= 1'b1;
          end
        end
      end else div <= div + 1'b1;
    end

  assign mosi = tsr[31];

  wire [2:0] ev_clr = w_clr ? reg_wdata[4:2] : 3'b000;
  wire [2:0] ev_set = {tx_pop && tx_cnt == CW'(1) && !tx_push, ovf, fin};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ev <= '0;
    else        ev <= (ev & ~ev_clr) | ev_set;

  wire [31:0] raw32  = {27'b0, ev, 2'b00};
  wire [31:0] msk32  = raw32 & ctrl;
  wire [31:0] stat32 = {18'b0, !busy, 1'b0, tx_full, tx_empty, 2'b00,
                        rx_full, rx_empty, 5'b0, busy};
  wire [31:0] stat8  = {27'b0, tx_full, rx_full, tx_empty, rx_empty, !busy};

  assign irq_xfer = msk32[2] | msk32[4];
  assign irq_err  = msk32[3];

  always_comb
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl;
      A_FSZ:   reg_rdata = {26'b0, fsz};
      A_STAT:  reg_rdata = stat32;
      A_CLK:   reg_rdata = 32'(cgen);
      A_RXD:   reg_rdata = rx_empty ? 32'b0 : rx_mem[rx_rp];
      A_RAW:   reg_rdata = raw32;
      A_MSK:   reg_rdata = msk32;
      A_ST8:   reg_rdata = stat8;
      default: reg_rdata = 32'b0;
    endcase
endmodule

// File: rtl/spi_wfifo_master_chk.sv
module spi_wfifo_master_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sclk,
  input logic          cs_n,
  input logic          busy,
  input logic          ctrl_en,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] depth,
  input logic          w_fsz,
  input logic          w_clr,
  input logic          clr_done,
  input logic          fin,
  input logic          raw_done
);
  a_r2_tx_bound: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= depth);
  a_r9_rx_bound: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= depth);
  a_r4_flush: assert property (@(posedge clk) disable iff (!rst_n)
    w_fsz |=> (tx_cnt == '0 && rx_cnt == '0));
  a_r10_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !busy) |=> !busy);
  a_r6_sclk_framed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !cs_n);
  a_r8_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
    (w_clr && clr_done && !fin) |=> !raw_done);
endmodule

bind spi_wfifo_master spi_wfifo_master_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .busy(busy),
  .ctrl_en(ctrl[0]), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .depth(depth),
  .w_fsz(w_fsz), .w_clr(w_clr), .clr_done(reg_wdata[2]), .fin(fin),
  .raw_done(ev[0])
);

// File: tb/sim_spi_wfifo_master.sv
`timescale 1ns/1ps
module sim_spi_wfifo_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sclk, mosi, miso, cs_n, irq_xfer, irq_err;
  int          n_run = 0, n_fail = 0;

  assign miso = mosi;
  always #2.5 clk = ~clk;

  spi_wfifo_master u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_n(cs_n), .irq_xfer(irq_xfer), .irq_err(irq_err));

  int          cyc = 0, last_rise = 0, period = 0, frames = 0;
  logic [31:0] mon = '0;
  always @(negedge clk) cyc <= cyc + 1;
  always @(posedge sclk) begin
    period    <= cyc - last_rise;
    last_rise <= cyc;
    mon       <= {mon[30:0], mosi};
  end
  always @(negedge cs_n) frames <= frames + 1;

  localparam logic [11:0] DEPTHS [8] = '{
    {6'd0, 6'd32}, {6'd8, 6'd32}, {6'd1, 6'd32}, {6'd9, 6'd16},
    {6'd16, 6'd16}, {6'd17, 6'd8}, {6'd32, 6'd8}, {6'd24, 6'd8}};
  localparam logic [37:0] FRAMES [6] = '{
    {6'd8, 32'h0000_00A5}, {6'd12, 32'h0000_0ABC}, {6'd32, 32'hDEAD_BEEF},
    {6'd1, 32'h0000_0001}, {6'd0, 32'h0000_0001}, {6'd40, 32'h8123_4567}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(6'h08, s);
      if (s[0] == 1'b0 && s[10] == 1'b1) return;
    end
    chk("R5 wait_idle timeout", 32'd1, 32'd0);
  endtask

  initial begin
    #(5.0 * 190000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [5:0]  nbits;
    logic [31:0] mask;
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(6'h00, v); chk("R1 ctrl", v, 32'h8102);
    rd(6'h04, v); chk("R1 fsize", v, 32'h4);
    rd(6'h08, v); chk("R1 status", v, 32'h2440);
    rd(6'h0C, v); chk("R1 divider", v, 32'h7);
    rd(6'h24, v); chk("R1 compact", v, 32'h7);
    rd(6'h18, v); chk("R1 raw", v, 32'h0);
    rd(6'h1C, v); chk("R1 masked", v, 32'h0);
    chk("R1 pins", {28'b0, cs_n, sclk, irq_xfer, irq_err}, 32'h8);

    rd(6'h14, v); chk("R12 empty rx read", v, 32'h0);
    rd(6'h08, v); chk("R12 status unchanged", v, 32'h2440);

    for (int i = 1; i <= 3; i++) wr(6'h10, i);
    rd(6'h08, v); chk("R2 not full at 3", v, 32'h2040);
    wr(6'h10, 4);
    rd(6'h08, v); chk("R2 full at 4", v, 32'h2840);
    wr(6'h10, 5);
    f0 = frames;
    repeat (100) @(negedge clk);
    chk("R10 no frame while disabled", frames - f0, 0);
    chk("R10 cs_n idle", {31'b0, cs_n}, 32'h1);
    rd(6'h08, v); chk("R10 tx still full", v, 32'h2840);

    wr(6'h0C, 0);
    wr(6'h00, 1);
    wait_idle();
    chk("R2 fifth write dropped", frames - f0, 4);
    for (int i = 1; i <= 4; i++) begin
      rd(6'h14, v); chk("R5 default 4-bit frame", v, i);
    end
    rd(6'h14, v); chk("R12 rx empty after drain", v, 32'h0);

    wr(6'h00, 0);
    foreach (DEPTHS[k]) begin
      wr(6'h10, 32'h55);
      wr(6'h04, {26'b0, DEPTHS[k][11:6]});
      rd(6'h08, v); chk("R4 flush on fsize write", v & 32'h440, 32'h440);
      for (int i = 0; i < int'(DEPTHS[k][5:0]) - 1; i++) wr(6'h10, i);
      rd(6'h08, v); chk("R3 not full at depth-1", {31'b0, v[11]}, 32'h0);
      wr(6'h10, 32'hFF);
      rd(6'h08, v); chk("R3 full at depth", {31'b0, v[11]}, 32'h1);
    end

    wr(6'h04, 8);
    wr(6'h00, 1);
    foreach (FRAMES[k]) begin
      wr(6'h04, {26'b0, FRAMES[k][37:32]});
      nbits = (FRAMES[k][37:32] == 0) ? 6'd1 : (FRAMES[k][37:32] > 32) ? 6'd32 : FRAMES[k][37:32];
      mask  = (nbits == 6'd32) ? 32'hFFFF_FFFF : ((32'd1 << nbits) - 32'd1);
      wr(6'h10, FRAMES[k][31:0]);
      wait_idle();
      rd(6'h14, v); chk("R5 loopback data", v, FRAMES[k][31:0] & mask);
      chk("R5 msb-first on mosi", mon & mask, FRAMES[k][31:0] & mask);
    end

    wr(6'h0C, 2);
    wr(6'h04, 8);
    wr(6'h18, 32'h1C);
    wr(6'h20, 32'h1C);
    wr(6'h00, 32'h5);
    wr(6'h10, 32'hC3);
    wait_idle();
    chk("R6 sclk period at D=2", period, 6);
    chk("R6 cs_n high after frame", {31'b0, cs_n}, 32'h1);
    rd(6'h14, v); chk("R6 data at D=2", v, 32'hC3);
    rd(6'h18, v); chk("R11 drained and R5 done raw", v, 32'h14);
    rd(6'h1C, v); chk("R7 masked", v, 32'h04);
    chk("R7 irq lines", {30'b0, irq_xfer, irq_err}, 32'h2);
    wr(6'h20, 32'h04);
    rd(6'h18, v); chk("R8 only bit2 cleared", v, 32'h10);
    chk("R8 irq_xfer low", {31'b0, irq_xfer}, 32'h0);
    rd(6'h00, v); chk("R8 ctrl untouched", v, 32'h5);
    wr(6'h20, 32'h10);
    rd(6'h18, v); chk("R8 all cleared", v, 32'h0);

    wr(6'h0C, 0);
    wr(6'h00, 32'h9);
    wr(6'h04, 32);
    for (int i = 1; i <= 9; i++) wr(6'h10, i);
    wait_idle();
    rd(6'h08, v); chk("R9 rx full", {31'b0, v[7]}, 32'h1);
    rd(6'h18, v); chk("R9 overflow raw", v & 32'h8, 32'h8);
    chk("R9 irq_err", {31'b0, irq_err}, 32'h1);
    rd(6'h14, v); chk("R9 oldest kept", v, 32'h1);
    wr(6'h04, 32);
    rd(6'h08, v); chk("R4 rx flushed", v & 32'h440, 32'h440);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule